// File: doc/BRIEF.md
# GPIO port interrupt detector

This block watches the 32 input pins of one general-purpose I/O port and turns selected pin activity into a single interrupt request for a parent interrupt controller. For each pin, software picks one of four trigger conditions: rising edge, falling edge, high level or low level. The pins are first brought into the clock domain, and each qualifying event sets a sticky bit in a status register. A mask register decides which status bits may drive the port's summary interrupt line.

Software configures the port through a small write/read register file. It programs the trigger codes, marks pins as used for GPIO and as inputs, and opens the mask. When the port line rises, the handler reads the status word, scans it from pin 0 upward and acknowledges each pin by writing a 1 to its status bit. A pin only takes part when it is flagged as a GPIO pin and its direction bit selects input.

Top module: `gpio_irq_port`

## Requirements
- R1: Trigger code 0 fires on a rising edge, 1 on a falling edge, 2 while the pin is high and 3 while the pin is low.
- R2: Pins 0 to 15 take their 2-bit trigger code from the low trigger word (address 0) and pins 16 to 31 from the high trigger word (address 1), in both cases at bits [2*(pin mod 16)+1 : 2*(pin mod 16)].
- R3: Writing the status register (address 3) clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R4: The port interrupt line is high exactly when some pin has both its status bit and its mask bit (mask register, address 2) set to 1.
- R5: After reset all registers (trigger words, mask, status, GPIO-use at address 4, direction at address 5) read 0 and the port interrupt line is low.
- R6: A pin whose GPIO-use bit is 0 or whose direction bit is 1 (output) never sets its status bit.
- R7: Each pin goes through two synchronizing flops. A pin change applied before clock edge k shows in the status register after edge k+2, and not earlier.
- R8: Under a level code the status bit is set again on every cycle the level holds, so a clear has no lasting effect until the level ends.
- R9: When an event and a clear hit the same status bit in the same cycle, the bit remains set.
- R10: The trigger words, mask, GPIO-use and direction registers read back the value last written. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 32 | Raw pin levels from the port pads |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| port_irq | output | 1 | Port interrupt request to the parent controller |

## Verification
Directed pin patterns use one pin per trigger code. A single rising step on an edge pin is checked in each of the three cycles after the change, which separates a correct two-flop latency from a shorter or longer one. A held level against a clear, and an edge timed to land in the same cycle as a clear, separate level re-arming and set-over-clear priority from plain write-1-to-clear. Random phases then apply sparse random toggles under random trigger words, use and direction flags and masks, with random clears. These are compared each cycle against a reference model, which exposes swapped codes, wrong word halves and leaks from disabled pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        ADDR_TRIG_LO = 3'd0,
        ADDR_TRIG_HI = 3'd1,
        ADDR_MASK    = 3'd2,
        ADDR_STAT    = 3'd3,
        ADDR_USE     = 3'd4,
        ADDR_DIR     = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_LOW  = 2'd3
    } trig_e;

    localparam int TRIG_W = 2;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int N_PINS = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_in,
    output logic [N_PINS-1:0] cur_o,
    output logic [N_PINS-1:0] prev_o
);
    logic [N_PINS-1:0] chain_q [STAGES];
    logic [N_PINS-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= pins_in;
                end else begin
                    chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign cur_o  = chain_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 32,
    localparam int CFG_W = N_PINS * TRIG_W
) (
    input  logic [CFG_W-1:0]  trig_cfg,
    input  logic [N_PINS-1:0] enable,
    input  logic [N_PINS-1:0] cur,
    input  logic [N_PINS-1:0] prev,
    output logic [N_PINS-1:0] event_o
);
    genvar i;
    generate
        for (i = 0; i < N_PINS; i++) begin : g_pin
            trig_e code;
            logic  hit;
            assign code = trig_e'(trig_cfg[TRIG_W*i +: TRIG_W]);

            always_comb begin
                unique case (code)
                    TRIG_RISE: hit = cur[i] & ~prev[i];
                    TRIG_FALL: hit = ~cur[i] & prev[i];
                    TRIG_HIGH: hit = cur[i];
                    TRIG_LOW:  hit = ~cur[i];
                    default:   hit = 1'b0;
                endcase
            end

            assign event_o[i] = hit & enable[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 32,
    localparam int CFG_W = N_PINS * TRIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [N_PINS-1:0] wdata,
    output logic [N_PINS-1:0] rdata,
    input  logic [N_PINS-1:0] event_in,
    output logic [CFG_W-1:0]  trig_cfg,
    output logic [N_PINS-1:0] enable,
    output logic [N_PINS-1:0] mask,
    output logic [N_PINS-1:0] status
);
    reg_addr_e         sel;
    logic [N_PINS-1:0] trig_lo_q, trig_hi_q, mask_q, stat_q, use_q, dir_q;
    logic [N_PINS-1:0] clr;

    assign sel = reg_addr_e'(addr);
    assign clr = (wr && sel == ADDR_STAT) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_lo_q <= '0;
            trig_hi_q <= '0;
            mask_q    <= '0;
            use_q     <= '0;
            dir_q     <= '0;
        end else if (wr) begin
            case (sel)
                ADDR_TRIG_LO: trig_lo_q <= wdata;
                ADDR_TRIG_HI: trig_hi_q <= wdata;
                ADDR_MASK:    mask_q    <= wdata;
                ADDR_USE:     use_q     <= wdata;
                ADDR_DIR:     dir_q     <= wdata;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | event_in;
        end
    end

    always_comb begin
        case (sel)
            ADDR_TRIG_LO: rdata = trig_lo_q;
            ADDR_TRIG_HI: rdata = trig_hi_q;
            ADDR_MASK:    rdata = mask_q;
            ADDR_STAT:    rdata = stat_q;
            ADDR_USE:     rdata = use_q;
            ADDR_DIR:     rdata = dir_q;
            default:      rdata = '0;
        endcase
    end

    assign trig_cfg = {trig_hi_q, trig_lo_q};
    assign enable   = use_q & ~dir_q;
    assign mask     = mask_q;
    assign status   = stat_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 32,
    localparam int CFG_W = N_PINS * TRIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_in,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [N_PINS-1:0] reg_wdata,
    output logic [N_PINS-1:0] reg_rdata,
    output logic              port_irq
);
    logic [N_PINS-1:0] pin_cur, pin_prev, pin_event, pin_enable;
    logic [N_PINS-1:0] mask_q, status_q;
    logic [CFG_W-1:0]  trig_cfg;

    gpio_irq_sync #(.N_PINS(N_PINS), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_in(pins_in),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
        .trig_cfg(trig_cfg),
        .enable  (pin_enable),
        .cur     (pin_cur),
        .prev    (pin_prev),
        .event_o (pin_event)
    );

    gpio_irq_regs #(.N_PINS(N_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .event_in(pin_event),
        .trig_cfg(trig_cfg),
        .enable  (pin_enable),
        .mask    (mask_q),
        .status  (status_q)
    );

    assign port_irq = |(status_q & mask_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [N_PINS-1:0] reg_wdata,
    input logic [N_PINS-1:0] status,
    input logic [N_PINS-1:0] mask,
    input logic [N_PINS-1:0] enable,
    input logic [N_PINS-1:0] event_vec,
    input logic              port_irq
);
    assert_reset_clear_R5: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && mask == '0));

    assert_closed_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !port_irq);

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STAT)
        |=> ((status & $past(reg_wdata) & ~$past(event_vec)) == '0));

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(enable)) == '0));

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(event_vec) & ~status) == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .status   (status_q),
    .mask     (mask_q),
    .enable   (pin_enable),
    .event_vec(pin_event),
    .port_irq (port_irq)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins_in = '0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         port_irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    gpio_irq_port #(.N_PINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_irq(port_irq)
    );

    // reference model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_p, m_stat, m_mask, m_lo, m_hi, m_use, m_dir;

    function automatic logic ref_hit(logic [1:0] code, logic c, logic p);
        case (code)
            2'd0: return c & ~p;
            2'd1: return ~c & p;
            2'd2: return c;
            default: return ~c;
        endcase
    endfunction

    function automatic logic [N-1:0] ref_events();
        logic [N-1:0] ev;
        for (int i = 0; i < N; i++) begin
            logic [1:0] code;
            code = (i < 16) ? m_lo[2*i +: 2] : m_hi[2*(i-16) +: 2];
            ev[i] = ref_hit(code, m_s2[i], m_p[i]) & m_use[i] & ~m_dir[i];
        end
        return ev;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_stat <= '0; m_mask <= '0;
            m_lo <= '0; m_hi <= '0; m_use <= '0; m_dir <= '0;
        end else begin
            m_s1 <= pins_in;
            m_s2 <= m_s1;
            m_p  <= m_s2;
            m_stat <= (m_stat & ~((reg_wr && reg_addr == 3'd3) ? reg_wdata : '0)) | ref_events();
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_lo   <= reg_wdata;
                    3'd1: m_hi   <= reg_wdata;
                    3'd2: m_mask <= reg_wdata;
                    3'd4: m_use  <= reg_wdata;
                    3'd5: m_dir  <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [N-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // called just after a falling edge; write lands on the next rising edge
    task automatic wr_now(input logic [2:0] a, input logic [N-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    logic [N-1:0] v;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R5: reset state
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), v);
            chk("R5 reset reg", v, '0);
        end
        chk("R5 reset irq", {31'd0, port_irq}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        pins_in = 32'h8010_0000;
        repeat (4) @(negedge clk);
        // R2: pin3 rise(0), pin7 high(2), pin10 rise, pin20 fall(1), pin31 low(3)
        wr_now(3'd0, 32'h0000_8000);
        wr_now(3'd1, 32'hC000_0100);
        wr_now(3'd5, 32'h0000_0400);
        wr_now(3'd4, 32'h8010_0488);
        peek(3'd0, v); chk("R10 trig lo", v, 32'h0000_8000);
        peek(3'd1, v); chk("R10 trig hi", v, 32'hC000_0100);
        peek(3'd4, v); chk("R10 use", v, 32'h8010_0488);
        peek(3'd5, v); chk("R10 dir", v, 32'h0000_0400);
        peek(3'd6, v); chk("R10 unused addr", v, '0);
        wr_now(3'd3, '1);
        peek(3'd3, v); chk("R3 clear all", v, '0);

        // R7 / R1 rising edge latency on pin 3
        @(negedge clk); pins_in[3] = 1'b1;
        @(negedge clk); peek(3'd3, v); chk("R7 after k", v, '0);
        @(negedge clk); peek(3'd3, v); chk("R7 after k+1", v, '0);
        @(negedge clk); peek(3'd3, v); chk("R7 R1 rise after k+2", v, 32'h8);
        chk("R4 mask closed", {31'd0, port_irq}, '0);
        wr_now(3'd2, 32'h8);
        chk("R4 mask open", {31'd0, port_irq}, 32'd1);

        // R1 / R2 falling edge on pin 20 (high word)
        pins_in[20] = 1'b0;
        repeat (3) @(negedge clk);
        peek(3'd3, v); chk("R1 R2 fall pin20", v, 32'h0010_0008);
        wr_now(3'd3, 32'h0010_0000);
        peek(3'd3, v); chk("R3 zero bits kept", v, 32'h8);
        wr_now(3'd3, 32'h8);
        peek(3'd3, v); chk("R3 one bit cleared", v, '0);
        chk("R4 irq drops", {31'd0, port_irq}, '0);

        // R6 output pin ignored
        pins_in[10] = 1'b1;
        repeat (4) @(negedge clk);
        peek(3'd3, v); chk("R6 output pin ignored", v, '0);

        // R8 high level pin 7
        pins_in[7] = 1'b1;
        repeat (3) @(negedge clk);
        peek(3'd3, v); chk("R1 high level", v, 32'h80);
        wr_now(3'd3, 32'h80);
        peek(3'd3, v); chk("R8 level re-sets", v, 32'h80);
        pins_in[7] = 1'b0;
        repeat (3) @(negedge clk);
        wr_now(3'd3, 32'h80);
        peek(3'd3, v); chk("R8 clear after level ends", v, '0);

        // R9 edge and clear in the same cycle
        pins_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        wr_now(3'd3, '1);
        pins_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_now(3'd3, 32'h8);
        peek(3'd3, v); chk("R9 set wins", v, 32'h8);
        wr_now(3'd3, 32'h8);
        peek(3'd3, v); chk("R9 later clear", v, '0);

        // R1 low level pin 31, masked out
        pins_in[31] = 1'b0;
        repeat (3) @(negedge clk);
        peek(3'd3, v); chk("R1 low level", v, 32'h8000_0000);
        chk("R4 masked pin", {31'd0, port_irq}, '0);
        pins_in[31] = 1'b1;
        repeat (3) @(negedge clk);
        wr_now(3'd3, '1);

        // random phases against the model
        for (int seg = 0; seg < 4; seg++) begin
            wr_now(3'd0, $urandom);
            wr_now(3'd1, $urandom);
            wr_now(3'd4, $urandom | $urandom);
            wr_now(3'd5, $urandom & $urandom & $urandom);
            wr_now(3'd2, $urandom);
            for (int c = 0; c < 500; c++) begin
                @(negedge clk);
                reg_wr = 1'b0;
                peek(3'd3, v);
                chk("R1 R2 R3 R6 R8 R9 random status", v, m_stat);
                chk("R4 random irq", {31'd0, port_irq}, {31'd0, |(m_stat & m_mask)});
                pins_in = pins_in ^ ($urandom & $urandom & $urandom);
                if ($urandom_range(0, 3) == 0) begin
                    reg_addr = 3'd3; reg_wdata = $urandom; reg_wr = 1'b1;
                end else if ($urandom_range(0, 63) == 0) begin
                    reg_addr = 3'd2; reg_wdata = $urandom; reg_wr = 1'b1;
                end
            end
            @(negedge clk);
            reg_wr = 1'b0;
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule